// File: doc/BRIEF.md
# Instruction-Driven SPI Sequencer

This block is an SPI master that software does not poke bit by bit. Instead, it runs a stream of 16-bit instruction words from a command queue. Each word does one of four things: it moves a run of bytes over the bus, it changes the chip-select lines after a programmable pause, it loads one of two internal settings (the clock divider and the bus mode), or it does a miscellaneous action. The miscellaneous actions are an idle pause counted in SCLK periods and a sync marker. The sync marker tells the host that everything queued before it has finished.

Outgoing bytes come from a transmit byte queue and received bytes go to a receive byte queue, both through valid/ready handshakes. The queues, the register decoding and the host side sit outside the block. When an input it needs is missing, the engine waits without error. Only 8-bit words are moved, most significant bit first.

Top module: `spi_seq_engine`

## Requirements
- R1: After reset the chip selects are all high, SCLK is 0, the divider and the mode setting are 0, SDO is driven (output enable 1), `cmd_ready` is 1, and `sync_valid`, `sdo_ready` and `sdi_valid` are 0.
- R2: An instruction word has opcode in [15:12], first argument in [11:8] and second argument in [7:0]. `cmd_ready` is high only while no instruction is executing. A word is taken on a clock where `cmd_valid` and `cmd_ready` are both high.
- R3: Opcode 2 with first argument 0 loads the divider from the second argument. With first argument 1 it loads the mode setting from bits [2:0] of the second argument: bit 0 selects the late sampling phase, bit 1 the idle-high clock, bit 2 the shared-data-line mode. The new setting holds from the next clock, so the idle SCLK level equals the mode bit 1 last loaded.
- R4: During a transfer each SCLK half period lasts divider+1 clocks and each byte takes 16 half periods. SDO carries the byte most significant bit first, with each bit held for one full SCLK period.
- R5: With mode bit 0 clear, the input bit is sampled at the end of the first half of each bit period. With it set, the bit is sampled at the end of the second half. The eight samples form the received byte, first sample in bit 7.
- R6: Opcode 0 moves second-argument+1 bytes (1 to 256). Bit 0 of the first argument fetches each byte from the transmit queue. Bit 1 of the first argument offers each received byte on `sdi_valid`/`sdi_data`.
- R7: In a transfer without the fetch flag, SDO stays 0 and the transmit queue is not popped. In a transfer without the offer flag, received bytes are dropped and `sdi_valid` stays 0.
- R8: When a byte must be fetched and `sdo_valid` is low, the engine waits with `sdo_ready` held high. When a byte must be offered and `sdi_ready` is low, it waits with `sdi_valid` high and `sdi_data` unchanged.
- R9: Opcode 1 places bits of the second argument on the active-low chip selects. This happens first-argument×2×(divider+1)+1 clocks after the word is taken, and `cmd_ready` stays low until then.
- R10: Opcode 3 with first argument 1 keeps the engine busy for (second-argument+1)×2×(divider+1)+1 clocks and has no effect on the bus pins.
- R11: Opcode 3 with first argument 0 raises `sync_valid` for exactly the clock after the word is taken, with `sync_id` equal to its second argument. `sync_id` holds that value afterwards.
- R12: In shared-line mode, a transfer that reads without fetching drives the output enable low for its whole duration and samples the shared line input. All other cases drive the output enable high.
- R13: Opcodes 4 to 15, opcode 2 with a first argument above 1, and opcode 3 with a first argument above 1 are taken and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Instruction word available |
| cmd_ready | output | 1 | Engine takes an instruction |
| cmd_data | input | 16 | Instruction word |
| sdo_valid | input | 1 | Transmit byte available |
| sdo_ready | output | 1 | Engine takes a transmit byte |
| sdo_data | input | 8 | Transmit byte |
| sdi_valid | output | 1 | Received byte offered |
| sdi_ready | input | 1 | Receive queue has room |
| sdi_data | output | 8 | Received byte |
| sync_valid | output | 1 | One-clock sync marker |
| sync_id | output | 8 | Identifier of the last sync marker |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable of the data-out pad |
| spi_mosi_in | input | 1 | Data-out pad input, used in shared-line mode |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The bench builds the engine with its default of eight chip-select lines. With eight lines, every bit of the second argument of the chip-select opcode reaches a pin, and walking zero patterns expose any bit misplacement. The default widths also let a single 256-byte transfer run and allow divider values of 0, 1 and 2. These cover the shortest half period, the ripple of the down-counter and all four phase/polarity combinations against a clock-exact model.

// File: rtl/spi_seq_engine.sv
module spi_seq_engine #(
  parameter int NCS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [15:0]    cmd_data,
  input  logic           sdo_valid,
  output logic           sdo_ready,
  input  logic [7:0]     sdo_data,
  output logic           sdi_valid,
  input  logic           sdi_ready,
  output logic [7:0]     sdi_data,
  output logic           sync_valid,
  output logic [7:0]     sync_id,
  output logic           spi_sclk,
  output logic           spi_mosi,
  output logic           spi_mosi_oe,
  input  logic           spi_mosi_in,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n
);
  localparam int WAIT_W = $clog2(256 * 512) + 2;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_LOAD, S_SHIFT, S_STORE} state_t;

  state_t             state;
  logic [7:0]         div_q;
  logic [2:0]         cfg_q;
  logic [WAIT_W-1:0]  wcnt;
  logic               cs_op;
  logic [NCS-1:0]     cs_next;
  logic [1:0]         flags;
  logic [7:0]         left;
  logic [7:0]         sh;
  logic [7:0]         rx;
  logic [7:0]         pc;
  logic               ph;
  logic [2:0]         bitc;

  wire [3:0] op   = cmd_data[15:12];
  wire [3:0] a1   = cmd_data[11:8];
  wire [7:0] a2   = cmd_data[7:0];
  wire       take = cmd_valid && cmd_ready;
  wire       din  = cfg_q[2] ? spi_mosi_in : spi_miso;
  wire       in_xfer = (state == S_LOAD) || (state == S_SHIFT) || (state == S_STORE);

  logic [8:0]        wait_n;
  logic [9:0]        period;
  logic [WAIT_W-1:0] wait_len;
  assign wait_n   = (op == 4'd1) ? {5'd0, a1} : ({1'b0, a2} + 9'd1);
  assign period   = {1'b0, div_q, 1'b0} + 10'd2;
  assign wait_len = WAIT_W'(wait_n) * WAIT_W'(period);

  assign cmd_ready   = (state == S_IDLE);
  assign sdo_ready   = (state == S_LOAD) && flags[0];
  assign sdi_valid   = (state == S_STORE) && flags[1];
  assign sdi_data    = rx;
  assign spi_sclk    = (state == S_SHIFT) ? (cfg_q[1] ^ ph ^ cfg_q[0]) : cfg_q[1];
  assign spi_mosi    = (state == S_SHIFT) && sh[7];
  assign spi_mosi_oe = !(in_xfer && cfg_q[2] && flags == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      div_q      <= '0;
      cfg_q      <= '0;
      wcnt       <= '0;
      cs_op      <= 1'b0;
      cs_next    <= '1;
      spi_cs_n   <= '1;
      flags      <= '0;
      left       <= '0;
      sh         <= '0;
      rx         <= '0;
      pc         <= '0;
      ph         <= 1'b0;
      bitc       <= '0;
      sync_valid <= 1'b0;
      sync_id    <= '0;
    end else begin
      sync_valid <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          case (op)
            4'd0: begin
              flags <= a1[1:0];
              left  <= a2;
              state <= S_LOAD;
            end
            4'd1: begin
              cs_next <= a2[NCS-1:0];
              cs_op   <= 1'b1;
              wcnt    <= wait_len;
              state   <= S_WAIT;
            end
            4'd2: begin
              if (a1 == 4'd0) div_q <= a2;
              else if (a1 == 4'd1) cfg_q <= a2[2:0];
            end
            4'd3: begin
              if (a1 == 4'd0) begin
                sync_valid <= 1'b1;
                sync_id    <= a2;
              end else if (a1 == 4'd1) begin
                cs_op <= 1'b0;
                wcnt  <= wait_len;
                state <= S_WAIT;
              end
            end
            default: ;
          endcase
        end
        S_WAIT: begin
          if (wcnt == '0) begin
            if (cs_op) spi_cs_n <= cs_next;
            state <= S_IDLE;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_LOAD: if (!flags[0] || sdo_valid) begin
          sh    <= flags[0] ? sdo_data : 8'd0;
          pc    <= div_q;
          ph    <= 1'b0;
          bitc  <= '0;
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          if (pc != 8'd0) begin
            pc <= pc - 8'd1;
          end else begin
            pc <= div_q;
            ph <= ~ph;
            if (ph == cfg_q[0]) rx <= {rx[6:0], din};
            if (ph) begin
              if (bitc == 3'd7) state <= S_STORE;
              else begin
                bitc <= bitc + 3'd1;
                sh   <= {sh[6:0], 1'b0};
              end
            end
          end
        end
        S_STORE: if (!flags[1] || sdi_ready) begin
          if (left == 8'd0) state <= S_IDLE;
          else begin
            left  <= left - 8'd1;
            state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_engine_chk.sv
module spi_seq_engine_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [15:0]    cmd_data,
  input logic           sdo_valid,
  input logic           sdo_ready,
  input logic           sdi_valid,
  input logic           sdi_ready,
  input logic [7:0]     sdi_data,
  input logic           sync_valid,
  input logic [7:0]     sync_id,
  input logic           spi_sclk,
  input logic           spi_mosi_oe,
  input logic [NCS-1:0] spi_cs_n,
  input logic [2:0]     cfg_q
);
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, sdo_ready, sdi_valid})); // R2

  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_sclk == cfg_q[1]); // R3

  AST_SDO_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_ready && !sdo_valid |=> sdo_ready); // R8

  AST_SDI_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sdi_valid && !sdi_ready |=> sdi_valid && $stable(sdi_data)); // R8

  AST_CS_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> cmd_ready); // R9

  AST_SYNC_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> $past(cmd_valid && cmd_ready && cmd_data[15:12] == 4'd3 && cmd_data[11:8] == 4'd0)); // R11

  AST_SYNC_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> sync_id == $past(cmd_data[7:0])); // R11

  AST_NO_FETCH_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_mosi_oe |-> !sdo_ready && cfg_q[2]); // R12
endmodule

bind spi_seq_engine spi_seq_engine_chk #(.NCS(NCS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .sdo_valid(sdo_valid), .sdo_ready(sdo_ready),
  .sdi_valid(sdi_valid), .sdi_ready(sdi_ready), .sdi_data(sdi_data),
  .sync_valid(sync_valid), .sync_id(sync_id), .spi_sclk(spi_sclk),
  .spi_mosi_oe(spi_mosi_oe), .spi_cs_n(spi_cs_n), .cfg_q(cfg_q)
);

// File: tb/spi_seq_engine_tb.sv
module spi_seq_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, sdo_valid = 0, sdi_ready = 1, miso = 0, mosi_in = 0;
  logic [15:0] cmd_data = 0;
  logic [7:0]  sdo_data = 0;
  logic        cmd_ready, sdo_ready, sdi_valid, sync_valid, sclk, mosi, mosi_oe;
  logic [7:0]  sdi_data, sync_id, cs_n;

  spi_seq_engine #(.NCS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .sdo_valid(sdo_valid), .sdo_ready(sdo_ready),
    .sdo_data(sdo_data), .sdi_valid(sdi_valid), .sdi_ready(sdi_ready),
    .sdi_data(sdi_data), .sync_valid(sync_valid), .sync_id(sync_id),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_mosi_oe(mosi_oe),
    .spi_mosi_in(mosi_in), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  logic [15:0] cmdq[$];
  logic [7:0]  txq[$];
  int checks = 0, fails = 0;
  bit cmp_en = 0, sdo_hold = 0, sdi_block = 0;
  logic [15:0] lf = 16'hACE1;
  int n_pop = 0, n_push = 0, exp_wr = 0, exp_rd = 0, seed = 5;

  // behavioural reference state
  int m_mode, m_e, m_total, m_cs_op, m_csnext, m_cs, m_div, m_cfg;
  int m_flags, m_left, m_tx, m_rx, m_sv, m_sid, m_ign, m_sleep;
  int op, a1, a2, h, k, din;
  bit acc_cmd, acc_sdo, acc_sdi;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    acc_cmd = 0; acc_sdo = 0; acc_sdi = 0;
    if (!rst_n) begin
      m_mode = 0; m_e = 0; m_total = 0; m_cs_op = 0; m_csnext = 255; m_cs = 255;
      m_div = 0; m_cfg = 0; m_flags = 0; m_left = 0; m_tx = 0; m_rx = 0;
      m_sv = 0; m_sid = 0; m_ign = 0; m_sleep = 0;
    end else begin
      m_sv = 0;
      din = ((m_cfg >> 2) & 1) != 0 ? int'(mosi_in) : int'(miso);
      case (m_mode)
        0: if (cmd_valid) begin
          acc_cmd = 1;
          op = int'(cmd_data[15:12]); a1 = int'(cmd_data[11:8]); a2 = int'(cmd_data[7:0]);
          m_ign = 0;
          if (op == 0) begin
            m_flags = a1 & 3; m_left = a2 + 1; m_mode = 2;
          end else if (op == 1) begin
            m_total = a1 * 2 * (m_div + 1); m_e = 0; m_cs_op = 1; m_csnext = a2;
            m_sleep = 0; m_mode = 1;
          end else if (op == 2) begin
            if (a1 == 0) m_div = a2; else if (a1 == 1) m_cfg = a2 & 7; else m_ign = 1;
          end else if (op == 3) begin
            if (a1 == 0) begin m_sv = 1; m_sid = a2; end
            else if (a1 == 1) begin
              m_total = (a2 + 1) * 2 * (m_div + 1); m_e = 0; m_cs_op = 0;
              m_sleep = 1; m_mode = 1;
            end else m_ign = 1;
          end else m_ign = 1;
        end
        1: if (m_e == m_total) begin
          if (m_cs_op != 0) m_cs = m_csnext;
          m_sleep = 0; m_mode = 0;
        end else m_e++;
        2: if ((m_flags & 1) == 0 || sdo_valid) begin
          acc_sdo = (m_flags & 1) != 0;
          m_tx = (m_flags & 1) != 0 ? int'(sdo_data) : 0;
          m_e = 0; m_mode = 3;
        end
        3: begin
          h = m_div + 1;
          if ((m_e + 1) % h == 0) begin
            k = m_e / h;
            if ((k % 2) == (m_cfg & 1)) m_rx = ((m_rx << 1) | din) & 255;
            if (k == 15) m_mode = 4;
          end
          m_e++;
        end
        4: if ((m_flags & 2) == 0 || sdi_ready) begin
          acc_sdi = (m_flags & 2) != 0;
          m_left--;
          m_mode = (m_left == 0) ? 0 : 2;
        end
        default: m_mode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      int e_sclk, e_mosi, e_oe, kk;
      e_sclk = (m_cfg >> 1) & 1; e_mosi = 0;
      if (m_mode == 3) begin
        kk = m_e / (m_div + 1);
        e_sclk = ((m_cfg >> 1) & 1) ^ (kk % 2) ^ (m_cfg & 1);
        e_mosi = (m_tx >> (7 - kk / 2)) & 1;
      end
      e_oe = (m_mode >= 2 && ((m_cfg >> 2) & 1) == 1 && m_flags == 2) ? 0 : 1;
      chk(m_mode == 1 && m_sleep == 1 ? "R10 cmd_ready" : (m_ign != 0 ? "R13 cmd_ready" : "R2 cmd_ready"),
          int'(cmd_ready), int'(m_mode == 0));
      chk("R8 sdo_ready", int'(sdo_ready), int'(m_mode == 2 && (m_flags & 1) != 0));
      chk("R6 sdi_valid", int'(sdi_valid), int'(m_mode == 4 && (m_flags & 2) != 0));
      if (m_mode == 4 && (m_flags & 2) != 0) chk("R5 sdi_data", int'(sdi_data), m_rx);
      chk(m_mode == 0 ? "R3 sclk idle" : "R4 sclk", int'(sclk), e_sclk);
      chk(m_mode == 3 && (m_flags & 1) == 0 ? "R7 mosi" : "R4 mosi", int'(mosi), e_mosi);
      chk("R12 mosi_oe", int'(mosi_oe), e_oe);
      chk("R9 cs_n", int'(cs_n), m_cs);
      chk("R11 sync_valid", int'(sync_valid), m_sv);
      chk("R11 sync_id", int'(sync_id), m_sid);
    end
    if (acc_cmd) void'(cmdq.pop_front());
    if (acc_sdo) begin void'(txq.pop_front()); n_pop++; end
    if (acc_sdi) n_push++;
    cmd_valid = rst_n && cmdq.size() > 0;
    cmd_data  = cmdq.size() > 0 ? cmdq[0] : 16'h0;
    sdo_valid = txq.size() > 0 && !sdo_hold;
    sdo_data  = txq.size() > 0 ? txq[0] : 8'h0;
    sdi_ready = !sdi_block;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    miso = lf[0];
    mosi_in = lf[7];
  end

  task automatic put(int o, int x, int y);
    cmdq.push_back({o[3:0], x[3:0], y[7:0]});
  endtask

  task automatic xfer(int fl, int n);
    put(0, fl, n - 1);
    if ((fl & 1) != 0) begin
      for (int i = 0; i < n; i++) begin
        seed = (seed * 37 + 11) & 255;
        txq.push_back(seed[7:0]);
      end
      exp_wr += n;
    end
    if ((fl & 2) != 0) exp_rd += n;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (cmdq.size() == 0 && cmd_ready) quiet++; else quiet = 0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 cs_n", int'(cs_n), 255);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 mosi_oe", int'(mosi_oe), 1);
    chk("R1 sync_valid", int'(sync_valid), 0);
    chk("R1 sdo_ready", int'(sdo_ready), 0);
    chk("R1 sdi_valid", int'(sdi_valid), 0);
    rst_n = 1'b1;
    cmp_en = 1;

    put(2, 0, 0); put(2, 1, 0);
    put(1, 0, 8'hFE); xfer(3, 2); put(1, 2, 8'hFF); put(3, 0, 8'h11);
    wait_idle();

    put(2, 0, 2); put(2, 1, 3); put(1, 1, 8'hFD);
    sdi_block = 1; xfer(2, 1);
    repeat (120) @(negedge clk);
    sdi_block = 0;
    sdo_hold = 1; xfer(1, 2);
    repeat (60) @(negedge clk);
    sdo_hold = 0;
    wait_idle();

    put(2, 0, 1);
    for (int c = 0; c < 4; c++) begin
      put(2, 1, c); xfer(3, 1); xfer(2, 1); xfer(1, 1);
    end
    wait_idle();

    for (int c = 4; c < 8; c++) begin
      put(2, 1, c); xfer(2, 2); xfer(1, 1); xfer(3, 1);
    end
    wait_idle();

    for (int b = 0; b < 8; b++) put(1, b & 3, 8'hFF ^ (1 << b));
    put(2, 0, 1); put(3, 1, 3); put(3, 0, 8'h22); put(3, 1, 0);
    wait_idle();

    put(5, 3, 8'h00); put(15, 15, 8'h5A); put(3, 2, 8'h33); put(2, 7, 8'h09); put(2, 2, 8'h01);
    xfer(3, 1);
    wait_idle();

    put(2, 0, 0); put(2, 1, 0); xfer(3, 256); xfer(0, 3);
    put(1, 0, 8'hFF); put(3, 0, 8'hAB);
    wait_idle();

    chk("R7 transmit bytes popped", n_pop, exp_wr);
    chk("R6 received bytes offered", n_push, exp_rd);
    finish_run();
  end
endmodule